// File: doc/BRIEF.md
# Multi-Mode Raster Timing Generator

This block produces the scan timing for an analog colour monitor. A horizontal counter steps through every pixel clock of a line, and a vertical counter steps once per line. Each line and each frame runs through four regions in a fixed order: the visible area, then a blanking gap before the sync pulse, then the sync pulse, then a blanking gap after it. The block outputs the current column and row, a display-enable flag, the horizontal and vertical sync levels, and the colour word. The colour word is forced to zero wherever the raster is outside the visible area.

The colour word is meant to go through a two-register DAC input stage outside the block. For that reason both sync outputs pass through a two-register delay before they leave the block, so they reach the connector in the same cycle as the colour they belong to. A composite-sync line for the DAC is tied high.

Three timing sets sit in a table parameter, and a 2-bit selector picks one of them:

| Code | Mode | Pixel clock | Line: visible / gap / sync / gap | Frame: visible / gap / sync / gap | Sync |
|------|------|-------------|----------------------------------|-----------------------------------|------|
| 0 | 640x480 | 25.175 MHz | 640 / 16 / 96 / 48 | 480 / 10 / 2 / 33 | active low |
| 1 | 800x600 at 56 Hz | 36 MHz | 800 / 24 / 72 / 128 | 600 / 1 / 2 / 22 | active high |
| 2 | 800x600 at 60 Hz | 40 MHz | 800 / 40 / 128 / 88 | 600 / 1 / 4 / 23 | active high |

The selector is sampled only at the frame boundary, so a change of mode never produces a partial frame.

Top module: `vgt_raster_top`

## Requirements
- R1: In each clock after reset, pix_x increases by one. In the clock after pix_x equals the line total of the current mode minus one, pix_x is 0. The line total is visible + front gap + sync + back gap.
- R2: pix_y changes only in the clock where pix_x wraps to 0. At that point it increases by one, or goes to 0 if it equalled the frame total minus one.
- R3: de is 1 exactly when pix_x is below the visible width and pix_y is below the visible height of the current mode.
- R4: The internal sync of a line is active while pix_x lies in [visible + front gap, visible + front gap + sync). The internal sync of a frame is active under the same rule applied to pix_y with the vertical values. The hsync and vsync outputs show each internal sync two clocks later.
- R5: Each table entry sets the sync polarity. In the default table, code 0 drives an active sync as 0, and codes 1 and 2 drive it as 1. An inactive sync is driven at the opposite level.
- R6: rgb_out equals rgb_in while de is 1 and is all zeros while de is 0.
- R7: csync_dac is 1 at all times.
- R8: mode_sel is taken only on the clock where pix_x and pix_y are both at their last counts. A change at any other time has no effect until that boundary. Codes 0, 1 and 2 select table entries 0, 1 and 2, and code 3 selects entry 0.
- R9: While rst_n is 0 at a clock edge, both counters go to 0, the sync delay stages clear, and mode_sel is loaded. Both sync outputs then stay inactive for the first two clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Requested timing mode code |
| rgb_in | input | 3*COLOR_W | Colour word from the pixel source |
| pix_x | output | CNT_W | Current column count |
| pix_y | output | CNT_W | Current row count |
| de | output | 1 | Visible-area flag |
| rgb_out | output | 3*COLOR_W | Colour word to the DAC, blanked outside the visible area |
| hsync | output | 1 | Horizontal sync to the connector, delayed two clocks |
| vsync | output | 1 | Vertical sync to the connector, delayed two clocks |
| csync_dac | output | 1 | Composite sync to the DAC, held at 1 |

## Verification
A wrong horizontal count shows on pix_x in the very next clock. It moves de and rgb_out at once, and it moves hsync two clocks later. A vertical counter that advances at the wrong moment shows on pix_y at the first clock where pix_x does not wrap.

A mode latched at the wrong time shows up within one line: the column count wraps at the wrong total and the sync polarity flips. A delay stage that is too short or too long, or that was not cleared, shifts the sync edges by a clock against the column count. The bench compares every clock of several frames in every mode, so that shift is caught at the first sync edge.

// File: rtl/vgt_pkg.sv
// Shared types and helpers for the raster timing generator.
// Assumes that every line total and frame total fits in CNT_W bits.
package vgt_pkg;

    localparam int CNT_W     = 12;
    localparam int NUM_MODES = 3;
    localparam int MODE_W    = $clog2(NUM_MODES + 1);

    // Timing of one mode: region lengths in clocks (lines for v_*), sync polarity.
    typedef struct packed {
        logic [CNT_W-1:0] h_act;
        logic [CNT_W-1:0] h_fp;
        logic [CNT_W-1:0] h_sw;
        logic [CNT_W-1:0] h_bp;
        logic [CNT_W-1:0] v_act;
        logic [CNT_W-1:0] v_fp;
        logic [CNT_W-1:0] v_sw;
        logic [CNT_W-1:0] v_bp;
        logic             sync_hi;
    } mode_timing_t;

    typedef mode_timing_t [NUM_MODES-1:0] timing_tab_t;

    // Build one table entry from plain integers.
    function automatic mode_timing_t mk_mode(int ha, int hf, int hs, int hb,
                                             int va, int vf, int vs, int vb, bit hi);
        mode_timing_t t;
        t.h_act   = CNT_W'(ha);
        t.h_fp    = CNT_W'(hf);
        t.h_sw    = CNT_W'(hs);
        t.h_bp    = CNT_W'(hb);
        t.v_act   = CNT_W'(va);
        t.v_fp    = CNT_W'(vf);
        t.v_sw    = CNT_W'(vs);
        t.v_bp    = CNT_W'(vb);
        t.sync_hi = hi;
        return t;
    endfunction

    localparam timing_tab_t DEFAULT_TAB = '{
        2: mk_mode(800, 40, 128,  88, 600,  1, 4, 23, 1'b1),
        1: mk_mode(800, 24,  72, 128, 600,  1, 2, 22, 1'b1),
        0: mk_mode(640, 16,  96,  48, 480, 10, 2, 33, 1'b0)
    };

    // Map an unused code onto entry 0.
    function automatic logic [MODE_W-1:0] pick_mode(logic [MODE_W-1:0] req);
        return (int'(req) < NUM_MODES) ? req : '0;
    endfunction

endpackage

// File: rtl/vgt_mode_latch.sv
// Holds the active timing mode. It reloads only at the frame boundary, or
// while reset is asserted, so a mode change never cuts a frame short.
// Assumes that frame_wrap is high for exactly the last clock of a frame.
module vgt_mode_latch
    import vgt_pkg::*;
#(
    parameter timing_tab_t TAB = DEFAULT_TAB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_req,
    input  logic              frame_wrap,
    output mode_timing_t      tm
);

    logic [MODE_W-1:0] cur_q;

    // Load the requested mode at reset and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_wrap) begin
            cur_q <= pick_mode(mode_req);
        end
    end

    assign tm = TAB[cur_q];

    // R8: away from the frame boundary the mode is held.
    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> $stable(cur_q));

endmodule

// File: rtl/vgt_raster_counter.sv
// Column and row counters of the raster. The row steps on the clock where the
// column wraps. Assumes totals of at least 1 that stay constant within a frame.
module vgt_raster_counter
    import vgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] h_total,
    input  logic [CNT_W-1:0] v_total,
    output logic [CNT_W-1:0] h_cnt,
    output logic [CNT_W-1:0] v_cnt,
    output logic             frame_wrap
);

    logic h_last;
    logic v_last;

    assign h_last     = (h_cnt == h_total - 1'b1);
    assign v_last     = (v_cnt == v_total - 1'b1);
    assign frame_wrap = h_last && v_last;

    // Step the column every clock and the row on each column wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (h_last) begin
            h_cnt <= '0;
            v_cnt <= v_last ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    // R1: the column steps by one inside a line.
    a_r1_h_step: assert property (@(posedge clk) disable iff (!rst_n)
        !h_last |=> h_cnt == $past(h_cnt) + 1'b1);

    // R1: the column returns to zero after its last count.
    a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        h_last |=> h_cnt == '0);

    // R2: the row holds except at a column wrap.
    a_r2_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !h_last |=> $stable(v_cnt));

endmodule

// File: rtl/vgt_sync_delay.sv
// Chain of DEPTH registers that retimes the sync bits to match the DAC
// input stage. Assumes DEPTH >= 1. Reset clears every stage to inactive.
module vgt_sync_delay #(
    parameter int DEPTH = 2,
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        // Stage g takes the input, or the stage before it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[g] <= '0;
            end else if (g == 0) begin
                stg[g] <= din;
            end else begin
                stg[g] <= stg[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign dout = stg[DEPTH-1];

    // R9: the first clock after reset shows inactive sync.
    a_r9_clear_out: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> dout == '0);

endmodule

// File: rtl/vgt_raster_top.sv
// Raster timing generator with a table of selectable modes. It decodes the
// sync windows from the counters, delays the sync outputs to line up with an
// external DAC input stage of SYNC_DELAY registers, and blanks the colour.
module vgt_raster_top
    import vgt_pkg::*;
#(
    parameter timing_tab_t MODE_TAB   = DEFAULT_TAB,
    parameter int          COLOR_W    = 8,
    parameter int          SYNC_DELAY = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    mode_sel,
    input  logic [3*COLOR_W-1:0] rgb_in,
    output logic [CNT_W-1:0]     pix_x,
    output logic [CNT_W-1:0]     pix_y,
    output logic                 de,
    output logic [3*COLOR_W-1:0] rgb_out,
    output logic                 hsync,
    output logic                 vsync,
    output logic                 csync_dac
);

    mode_timing_t     tm;
    logic             frame_wrap;
    logic [CNT_W-1:0] h_total, v_total;
    logic [CNT_W-1:0] hs_beg, hs_end, vs_beg, vs_end;
    logic [1:0]       sync_raw, sync_dly;

    vgt_mode_latch #(.TAB(MODE_TAB)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_req   (mode_sel),
        .frame_wrap (frame_wrap),
        .tm         (tm)
    );

    assign h_total = tm.h_act + tm.h_fp + tm.h_sw + tm.h_bp;
    assign v_total = tm.v_act + tm.v_fp + tm.v_sw + tm.v_bp;

    vgt_raster_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_total    (h_total),
        .v_total    (v_total),
        .h_cnt      (pix_x),
        .v_cnt      (pix_y),
        .frame_wrap (frame_wrap)
    );

    // Decode the sync windows, which follow the visible area and the front gap.
    always_comb begin
        hs_beg      = tm.h_act + tm.h_fp;
        hs_end      = hs_beg + tm.h_sw;
        vs_beg      = tm.v_act + tm.v_fp;
        vs_end      = vs_beg + tm.v_sw;
        sync_raw[0] = (pix_x >= hs_beg) && (pix_x < hs_end);
        sync_raw[1] = (pix_y >= vs_beg) && (pix_y < vs_end);
    end

    vgt_sync_delay #(.DEPTH(SYNC_DELAY), .WIDTH(2)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_raw),
        .dout  (sync_dly)
    );

    // Apply the polarity of the current mode to the delayed sync bits.
    always_comb begin
        hsync = tm.sync_hi ? sync_dly[0] : ~sync_dly[0];
        vsync = tm.sync_hi ? sync_dly[1] : ~sync_dly[1];
    end

    // Blank the colour outside the visible area.
    always_comb begin
        de      = (pix_x < tm.h_act) && (pix_y < tm.v_act);
        rgb_out = de ? rgb_in : '0;
    end

    assign csync_dac = 1'b1;

    // R6: colour is zero whenever the column or row is past the visible area.
    a_r6_blank_colour: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x >= tm.h_act || pix_y >= tm.v_act) |-> rgb_out == '0);

endmodule

// File: tb/vgt_raster_top_test.sv
// Scoreboard bench: a driver task models each clock and queues expected
// outputs, and a monitor compares them at the falling edge. Small timings keep
// full frames short.
module vgt_raster_top_test;
    import vgt_pkg::*;

    localparam int HA [3] = '{8, 10, 6};
    localparam int HF [3] = '{2, 1, 2};
    localparam int HS [3] = '{3, 2, 2};
    localparam int HB [3] = '{2, 3, 1};
    localparam int VA [3] = '{4, 5, 3};
    localparam int VF [3] = '{1, 1, 2};
    localparam int VS [3] = '{2, 1, 2};
    localparam int VB [3] = '{2, 1, 1};
    localparam bit HI [3] = '{1'b0, 1'b1, 1'b1};

    localparam timing_tab_t TB_TAB = '{
        2: mk_mode(6, 2, 2, 1, 3, 2, 2, 1, 1'b1),
        1: mk_mode(10, 1, 2, 3, 5, 1, 1, 1, 1'b1),
        0: mk_mode(8, 2, 3, 2, 4, 1, 2, 2, 1'b0)
    };

    logic              clk;
    logic              rst_n;
    logic [MODE_W-1:0] mode_sel;
    logic [23:0]       rgb_in;
    logic [CNT_W-1:0]  pix_x, pix_y;
    logic              de;
    logic [23:0]       rgb_out;
    logic              hsync, vsync, csync_dac;

    vgt_raster_top #(.MODE_TAB(TB_TAB), .COLOR_W(8), .SYNC_DELAY(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .rgb_in    (rgb_in),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .de        (de),
        .rgb_out   (rgb_out),
        .hsync     (hsync),
        .vsync     (vsync),
        .csync_dac (csync_dac)
    );

    typedef struct {
        int          x;
        int          y;
        bit          de;
        bit          hs;
        bit          vs;
        bit          hs_act;
        bit          vs_act;
        bit          pol;
        logic [23:0] rgb;
        bit          pend;
        bit          fresh;
    } exp_t;

    exp_t q [$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // Bench model state
    int mh = 0, mv = 0, mm = 0, since_rst = 0;
    bit p1h = 0, p2h = 0, p1v = 0, p2v = 0;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic int bmode(logic [1:0] c);
        return (c == 2'd3) ? 0 : int'(c);
    endfunction

    // Advance the model by one clock edge, using the inputs held before it.
    task automatic model_edge(logic r, logic [1:0] ms);
        bit rh, rv;
        if (!r) begin
            mh = 0; mv = 0; mm = bmode(ms);
            p1h = 0; p2h = 0; p1v = 0; p2v = 0;
            since_rst = 0;
        end else begin
            rh = (mh >= HA[mm] + HF[mm]) && (mh < HA[mm] + HF[mm] + HS[mm]);
            rv = (mv >= VA[mm] + VF[mm]) && (mv < VA[mm] + VF[mm] + VS[mm]);
            p2h = p1h; p1h = rh;
            p2v = p1v; p1v = rv;
            if (mh == HA[mm] + HF[mm] + HS[mm] + HB[mm] - 1) begin
                mh = 0;
                if (mv == VA[mm] + VF[mm] + VS[mm] + VB[mm] - 1) begin
                    mv = 0;
                    mm = bmode(ms);
                end else begin
                    mv++;
                end
            end else begin
                mh++;
            end
            since_rst++;
        end
    endtask

    // Driver: one clock, then set new inputs and queue the expected outputs.
    task automatic cyc(logic r, logic [1:0] ms, logic [23:0] rgb);
        exp_t e;
        @(posedge clk);
        model_edge(rst_n, mode_sel);
        rst_n    <= r;
        mode_sel <= ms;
        rgb_in   <= rgb;
        #1;
        e.x      = mh;
        e.y      = mv;
        e.de     = (mh < HA[mm]) && (mv < VA[mm]);
        e.hs_act = p2h;
        e.vs_act = p2v;
        e.pol    = HI[mm];
        e.hs     = HI[mm] ? p2h : !p2h;
        e.vs     = HI[mm] ? p2v : !p2v;
        e.rgb    = e.de ? rgb : 24'h0;
        e.pend   = (bmode(mode_sel) != mm);
        e.fresh  = (since_rst < 3);
        q.push_back(e);
    endtask

    task automatic chk(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d t=%0t)",
                     tag, act, expv, pix_x, pix_y, $time);
        end
    endtask

    // Monitor: compare the ports with the oldest queued expectation.
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk(int'(pix_x) == e.x, e.fresh ? "R9 pix_x" : (e.pend ? "R8 pix_x" : "R1 pix_x"),
                int'(pix_x), e.x);
            chk(int'(pix_y) == e.y, e.pend ? "R8 pix_y" : "R2 pix_y", int'(pix_y), e.y);
            chk(de == e.de, "R3 de", int'(de), int'(e.de));
            chk(hsync == e.hs, e.fresh ? "R9 hsync" : "R4 hsync", int'(hsync), int'(e.hs));
            chk(vsync == e.vs, e.fresh ? "R9 vsync" : "R4 vsync", int'(vsync), int'(e.vs));
            if (!e.hs_act && !e.vs_act) begin
                chk({hsync, vsync} == {!e.pol, !e.pol}, "R5 idle level",
                    int'({hsync, vsync}), int'({!e.pol, !e.pol}));
            end
            chk(rgb_out == e.rgb, "R6 rgb_out", int'(rgb_out), int'(e.rgb));
            chk(csync_dac == 1'b1, "R7 csync_dac", int'(csync_dac), 1);
        end
    end

    function automatic logic [23:0] pat(int i);
        logic [7:0] b;
        b = 8'(i);
        return {b, ~b, 8'(i * 3 + 1)};
    endfunction

    // Stimulus sequence.
    initial begin
        rst_n    = 1'b0;
        mode_sel = 2'd0;
        rgb_in   = 24'h0;
        for (int i = 0; i < 3; i++) cyc(1'b0, 2'd0, 24'hFFFFFF);
        // Mode 0, two frames, varying colour (R1..R7)
        for (int i = 0; i < 280; i++) cyc(1'b1, 2'd0, pat(i));
        // Mid-frame request of mode 1: held until the boundary (R8)
        for (int i = 0; i < 60; i++) cyc(1'b1, 2'd0, pat(i + 7));
        for (int i = 0; i < 300; i++) cyc(1'b1, 2'd1, 24'hFFFFFF);
        // Mode 2
        for (int i = 0; i < 250; i++) cyc(1'b1, 2'd2, pat(i * 5));
        // Unused code 3 falls back to entry 0 (R8)
        for (int i = 0; i < 300; i++) cyc(1'b1, 2'd3, pat(i + 100));
        // Reset in mid-frame, leaving with mode 1 loaded (R9)
        for (int i = 0; i < 2; i++) cyc(1'b0, 2'd1, 24'hA5A5A5);
        for (int i = 0; i < 200; i++) cyc(1'b1, 2'd1, pat(i + 3));
        // Reset leaving with mode 0, active-low sync (R9, R5)
        for (int i = 0; i < 2; i++) cyc(1'b0, 2'd0, 24'h123456);
        for (int i = 0; i < 300; i++) cyc(1'b1, 2'd0, pat(i * 11));
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #800000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule